// File: doc/BRIEF.md
# Pixel Mask, Blink and Color Selector

This block sits in the pixel path of a color lookup unit, after the serializer that turns each load period into individual pixels. For every pixel it takes an 8-bit palette index, two overlay bits and the blank and sync flags. It masks the index with a read mask, and it zeroes selected index bits while the blink phase is off. The overlay bits are gated by per-bit display and blink enables. The block then returns either the palette entry or one of four overlay colors. When blanking is active it drives a zero color.

The blink phase does not come from a free-running timer. It advances once per vertical retrace. A retrace is recognised when the blank flag stays active for a programmable number of consecutive load ticks, so the phase only changes while the screen is blanked. A two-bit rate field picks the on/off duty in frames. The palette itself is outside the block. The block drives a read address and expects the 24-bit word back in the same cycle.

Top module: `pixel_color_select`

## Requirements
- R1: The palette read address is the pixel index ANDed bitwise with `read_mask_i`.
- R2: An index bit whose `blink_mask_i` bit is 1 is forced to 0 only while the blink phase is off. In the on phase it passes unchanged.
- R3: `cmd_i[5:4]` selects the blink cycle in retrace events: 01 gives 16 on then 16 off, 10 gives 32 on then 32 off, and 00 or 11 gives 16 on then 48 off. After reset the phase is on with the frame count at zero, and the phase changes on no other occasion.
- R4: A retrace event occurs on the load tick that completes `RETRACE_LOADS` (default 256) consecutive load ticks with `pix_blank_ni` low. A blank run of one tick fewer gives no event. Only one event is counted per blank run, and the detector re-arms when `pix_blank_ni` goes high.
- R5: Overlay display enables are `ovl_ctl_i[0]` for overlay bit 0 and `ovl_ctl_i[1]` for overlay bit 1. A low enable forces that overlay bit to 0.
- R6: Overlay blink enables are `ovl_ctl_i[2]` for overlay bit 0 and `ovl_ctl_i[3]` for overlay bit 1. A high enable forces that overlay bit to 0 in the off phase.
- R7: When `cmd_i[6]` is 1 and both processed overlay bits are 0, the palette word is output. Otherwise the output is overlay color k, taken from `ovl_colors_i[24k+23:24k]`, where k is the processed overlay value. This gives overlay 0 when `cmd_i[6]` is 0 and the overlay value is 0.
- R8: A pixel with `pix_blank_ni` low produces `color_o` = 0, whatever its index and overlay inputs are.
- R9: A pixel presented before clock edge k appears on `color_o` after edge k+1. `sync_no` and `blank_no` carry that pixel's sync and blank flags with the same delay.
- R10: During reset, and until the pipeline refills, `color_o` is 0, `blank_no` is 0 and `sync_no` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_tick_i | input | 1 | One-cycle pulse per load period |
| pix_idx_i | input | IDX_W | Palette index of the pixel |
| pix_ovl_i | input | OVL_W | Overlay bits of the pixel |
| pix_blank_ni | input | 1 | Blank flag, active low |
| pix_sync_ni | input | 1 | Sync flag, active low |
| read_mask_i | input | IDX_W | Read mask for the index bit planes |
| blink_mask_i | input | IDX_W | Blink mask for the index bit planes |
| cmd_i | input | 8 | Bit 6 palette-on-zero-overlay, bits 5:4 blink rate |
| ovl_ctl_i | input | 2*OVL_W | Overlay display enables (low bits), blink enables (high bits) |
| pal_addr_o | output | IDX_W | Palette read address |
| pal_data_i | input | RGB_W | Palette word for `pal_addr_o`, same cycle |
| ovl_colors_i | input | 2**OVL_W*RGB_W | Overlay colors, color k at bits 24k and up |
| color_o | output | RGB_W | Selected pixel color |
| sync_no | output | 1 | Delayed sync flag, active low |
| blank_no | output | 1 | Delayed blank flag, active low |

## Verification
A wrong frame count or a missed retrace is invisible until the phase should flip. At that point a probe pixel that uses blink-masked index bits and a blink-enabled overlay bit returns the on-phase color where the off-phase color was due. The error therefore shows up on the first active line after the retrace that should have caused the flip. Errors in the mask or selection logic show on `color_o` two edges after the offending pixel. The random pixel streams are run in both phases, under every select and enable combination. Blank runs one tick short of the threshold, and runs much longer than it, check that the event fires exactly once.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  typedef enum logic [1:0] {
    BLINK_16_48 = 2'b00,
    BLINK_16_16 = 2'b01,
    BLINK_32_32 = 2'b10,
    BLINK_ALIAS = 2'b11
  } blink_rate_e;

  localparam int unsigned CNT_W = 7;

  function automatic logic [CNT_W-1:0] period_of(blink_rate_e r);
    case (r)
      BLINK_16_16: period_of = CNT_W'(32);
      default:     period_of = CNT_W'(64);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] on_len_of(blink_rate_e r);
    case (r)
      BLINK_32_32: on_len_of = CNT_W'(32);
      default:     on_len_of = CNT_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/pcs_retrace_det.sv
module pcs_retrace_det #(
  parameter int unsigned LOADS = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_tick_i,
  input  logic blank_ni,
  output logic evt_o
);
  localparam int unsigned CW = $clog2(LOADS + 1);

  logic [CW-1:0] cnt_q;
  logic          armed_q;

  assign evt_o = load_tick_i & ~blank_ni & armed_q & (cnt_q == CW'(LOADS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (blank_ni) begin
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (evt_o) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_tick_i && armed_q) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pcs_blink_timer.sv
module pcs_blink_timer
  import pcs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        evt_i,
  input  blink_rate_e rate_i,
  output logic        blink_off_o
);
  logic [CNT_W-1:0] frame_q, frame_inc, frame_d;

  assign frame_inc = frame_q + 1'b1;
  // a rate change may leave the count past the new period: wrap immediately
  assign frame_d   = (frame_inc >= period_of(rate_i)) ? '0 : frame_inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q     <= '0;
      blink_off_o <= 1'b0;
    end else if (evt_i) begin
      frame_q     <= frame_d;
      blink_off_o <= (frame_d >= on_len_of(rate_i));
    end
  end
endmodule

// File: rtl/pcs_pixel_stage.sv
module pcs_pixel_stage #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned OVL_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [OVL_W-1:0]   ovl_i,
  input  logic               blank_ni,
  input  logic               sync_ni,
  input  logic [IDX_W-1:0]   read_mask_i,
  input  logic [IDX_W-1:0]   blink_mask_i,
  input  logic [2*OVL_W-1:0] ovl_ctl_i,
  input  logic               pal_sel_i,
  input  logic               blink_off_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [OVL_W-1:0]   ovl_o,
  output logic               use_pal_o,
  output logic               blank_no,
  output logic               sync_no
);
  logic [IDX_W-1:0] idx_eff;
  logic [OVL_W-1:0] ovl_eff;

  assign idx_eff = idx_i & read_mask_i & ~(blink_mask_i & {IDX_W{blink_off_i}});

  for (genvar g = 0; g < OVL_W; g++) begin : g_ovl
    assign ovl_eff[g] = ovl_i[g] & ovl_ctl_i[g] & ~(ovl_ctl_i[OVL_W+g] & blink_off_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_o     <= '0;
      ovl_o     <= '0;
      use_pal_o <= 1'b0;
      blank_no  <= 1'b0;
      sync_no   <= 1'b1;
    end else begin
      idx_o     <= idx_eff;
      ovl_o     <= ovl_eff;
      use_pal_o <= pal_sel_i & (ovl_eff == '0);
      blank_no  <= blank_ni;
      sync_no   <= sync_ni;
    end
  end
endmodule

// File: rtl/pcs_color_stage.sv
module pcs_color_stage #(
  parameter int unsigned OVL_W = 2,
  parameter int unsigned RGB_W = 24
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [OVL_W-1:0]            ovl_i,
  input  logic                        use_pal_i,
  input  logic                        blank_ni,
  input  logic                        sync_ni,
  input  logic [RGB_W-1:0]            pal_data_i,
  input  logic [(2**OVL_W)*RGB_W-1:0] ovl_colors_i,
  output logic [RGB_W-1:0]            color_o,
  output logic                        blank_no,
  output logic                        sync_no
);
  localparam int unsigned N_OVL = 2 ** OVL_W;

  logic [RGB_W-1:0] ovl_arr [N_OVL];
  logic [RGB_W-1:0] color_d;

  for (genvar k = 0; k < N_OVL; k++) begin : g_unpack
    assign ovl_arr[k] = ovl_colors_i[k*RGB_W +: RGB_W];
  end

  always_comb begin
    if (!blank_ni)      color_d = '0;
    else if (use_pal_i) color_d = pal_data_i;
    else                color_d = ovl_arr[ovl_i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      color_o  <= '0;
      blank_no <= 1'b0;
      sync_no  <= 1'b1;
    end else begin
      color_o  <= color_d;
      blank_no <= blank_ni;
      sync_no  <= sync_ni;
    end
  end
endmodule

// File: rtl/pixel_color_select.sv
module pixel_color_select
  import pcs_pkg::*;
#(
  parameter int unsigned IDX_W         = 8,
  parameter int unsigned OVL_W         = 2,
  parameter int unsigned RGB_W         = 24,
  parameter int unsigned RETRACE_LOADS = 256
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        load_tick_i,
  input  logic [IDX_W-1:0]            pix_idx_i,
  input  logic [OVL_W-1:0]            pix_ovl_i,
  input  logic                        pix_blank_ni,
  input  logic                        pix_sync_ni,
  input  logic [IDX_W-1:0]            read_mask_i,
  input  logic [IDX_W-1:0]            blink_mask_i,
  input  logic [7:0]                  cmd_i,
  input  logic [2*OVL_W-1:0]          ovl_ctl_i,
  output logic [IDX_W-1:0]            pal_addr_o,
  input  logic [RGB_W-1:0]            pal_data_i,
  input  logic [(2**OVL_W)*RGB_W-1:0] ovl_colors_i,
  output logic [RGB_W-1:0]            color_o,
  output logic                        sync_no,
  output logic                        blank_no
);
  logic             retrace_evt;
  logic             blink_off;
  logic [OVL_W-1:0] s1_ovl;
  logic             s1_use_pal, s1_blank_n, s1_sync_n;

  pcs_retrace_det #(.LOADS(RETRACE_LOADS)) u_retrace (
    .clk_i, .rst_ni,
    .load_tick_i,
    .blank_ni (pix_blank_ni),
    .evt_o    (retrace_evt)
  );

  pcs_blink_timer u_blink (
    .clk_i, .rst_ni,
    .evt_i       (retrace_evt),
    .rate_i      (blink_rate_e'(cmd_i[5:4])),
    .blink_off_o (blink_off)
  );

  pcs_pixel_stage #(.IDX_W(IDX_W), .OVL_W(OVL_W)) u_stage1 (
    .clk_i, .rst_ni,
    .idx_i        (pix_idx_i),
    .ovl_i        (pix_ovl_i),
    .blank_ni     (pix_blank_ni),
    .sync_ni      (pix_sync_ni),
    .read_mask_i,
    .blink_mask_i,
    .ovl_ctl_i,
    .pal_sel_i    (cmd_i[6]),
    .blink_off_i  (blink_off),
    .idx_o        (pal_addr_o),
    .ovl_o        (s1_ovl),
    .use_pal_o    (s1_use_pal),
    .blank_no     (s1_blank_n),
    .sync_no      (s1_sync_n)
  );

  pcs_color_stage #(.OVL_W(OVL_W), .RGB_W(RGB_W)) u_stage2 (
    .clk_i, .rst_ni,
    .ovl_i        (s1_ovl),
    .use_pal_i    (s1_use_pal),
    .blank_ni     (s1_blank_n),
    .sync_ni      (s1_sync_n),
    .pal_data_i,
    .ovl_colors_i,
    .color_o,
    .blank_no,
    .sync_no
  );
endmodule

// File: rtl/pixel_color_select_chk.sv
module pixel_color_select_chk #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned OVL_W = 2,
  parameter int unsigned RGB_W = 24
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             load_tick_i,
  input logic [IDX_W-1:0] pix_idx_i,
  input logic             pix_blank_ni,
  input logic             pix_sync_ni,
  input logic [IDX_W-1:0] read_mask_i,
  input logic [IDX_W-1:0] blink_mask_i,
  input logic [IDX_W-1:0] pal_addr_o,
  input logic [RGB_W-1:0] color_o,
  input logic             sync_no,
  input logic             blank_no,
  input logic             retrace_evt,
  input logic             blink_off
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 1'b1;
  end

  assert_read_mask_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0) |-> ((pal_addr_o & ~$past(read_mask_i)) == '0));

  assert_on_phase_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && !$past(blink_off)) |-> (pal_addr_o == ($past(pix_idx_i) & $past(read_mask_i))));

  assert_off_phase_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != 2'd0 && $past(blink_off)) |-> ((pal_addr_o & $past(blink_mask_i)) == '0));

  assert_phase_only_on_retrace_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !retrace_evt |=> $stable(blink_off));

  assert_retrace_in_blank_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrace_evt |-> (load_tick_i && !pix_blank_ni));

  assert_retrace_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retrace_evt |=> !retrace_evt);

  assert_blank_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2 && !$past(pix_blank_ni, 2)) |-> (color_o == '0));

  assert_flag_delay_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q == 2'd2) |-> (blank_no == $past(pix_blank_ni, 2) && sync_no == $past(pix_sync_ni, 2)));
endmodule

bind pixel_color_select pixel_color_select_chk #(
  .IDX_W(IDX_W), .OVL_W(OVL_W), .RGB_W(RGB_W)
) u_chk (.*);

// File: tb/pixel_color_select_bench.sv
module pixel_color_select_bench;
  localparam int PERIOD = 10;
  localparam int LOADS  = 256;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        load_tick_i = 1'b0;
  logic [7:0]  pix_idx_i = '0;
  logic [1:0]  pix_ovl_i = '0;
  logic        pix_blank_ni = 1'b1;
  logic        pix_sync_ni = 1'b1;
  logic [7:0]  read_mask_i = 8'hFF;
  logic [7:0]  blink_mask_i = '0;
  logic [7:0]  cmd_i = 8'h50;
  logic [3:0]  ovl_ctl_i = 4'hF;
  logic [7:0]  pal_addr_o;
  logic [23:0] pal_data_i;
  logic [95:0] ovl_colors_i;
  logic [23:0] color_o;
  logic        sync_no, blank_no;

  int n_vec = 0;
  int n_bad = 0;
  int m_cnt = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  function automatic logic [23:0] pal_word(logic [7:0] a);
    return {a ^ 8'h5A, a + 8'd3, ~a};
  endfunction

  function automatic logic [23:0] ovl_word(int k);
    return {8'(k * 40 + 1), 8'(k * 17 + 200), 8'(k * 3 + 9)};
  endfunction

  assign pal_data_i = pal_word(pal_addr_o);
  for (genvar k = 0; k < 4; k++) begin : g_ovl
    assign ovl_colors_i[k*24 +: 24] = ovl_word(k);
  end

  pixel_color_select #(.RETRACE_LOADS(LOADS)) u_pixel_color_select (.*);

  function automatic int per_of(logic [1:0] r);
    return (r == 2'b01) ? 32 : 64;
  endfunction
  function automatic int on_of(logic [1:0] r);
    return (r == 2'b10) ? 32 : 16;
  endfunction
  function automatic bit model_off();
    return m_cnt >= on_of(cmd_i[5:4]);
  endfunction

  function automatic logic [23:0] exp_color(logic [7:0] idx, logic [1:0] ovl, logic bn, bit off);
    logic [7:0] a;
    logic [1:0] o;
    a = idx & read_mask_i & ~(blink_mask_i & {8{off}});
    for (int b = 0; b < 2; b++)
      o[b] = ovl[b] & ovl_ctl_i[b] & ~(ovl_ctl_i[b+2] & off);
    if (!bn) return '0;
    if (cmd_i[6] && o == 2'b00) return pal_word(a);
    return ovl_word(int'(o));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pixel(string req, logic [7:0] idx, logic [1:0] ovl, logic bn, logic sn, bit off);
    logic [23:0] e;
    @(negedge clk_i);
    pix_idx_i = idx; pix_ovl_i = ovl; pix_blank_ni = bn; pix_sync_ni = sn;
    e = exp_color(idx, ovl, bn, off);
    @(negedge clk_i);
    @(negedge clk_i);
    check(req, 32'(color_o), 32'(e));
    check("R9", 32'({blank_no, sync_no}), 32'({bn, sn}));
  endtask

  task automatic rand_pixels(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      read_mask_i  = 8'($urandom);
      blink_mask_i = 8'($urandom);
      ovl_ctl_i    = 4'($urandom);
      cmd_i        = {1'($urandom), 1'($urandom), cmd_i[5:4], 4'($urandom)};
      pixel("R1 R2 R5 R6 R7 R8", 8'($urandom), 2'($urandom),
            ($urandom % 8) != 0, 1'($urandom), model_off());
    end
  endtask

  // probe: index FF with low nibble blink-masked, overlay bit 0 blink-enabled
  task automatic probe(string req, bit off_exp);
    @(negedge clk_i);
    read_mask_i = 8'hFF; blink_mask_i = 8'h0F; ovl_ctl_i = 4'b1111;
    cmd_i = {1'b0, 1'b1, cmd_i[5:4], 4'h0};
    pixel(req, 8'hFF, 2'b01, 1'b1, 1'b1, off_exp);
  endtask

  task automatic blank_run(int n);
    @(negedge clk_i);
    pix_blank_ni = 1'b0; pix_sync_ni = 1'b0; load_tick_i = 1'b1;
    repeat (n) @(negedge clk_i);
    pix_blank_ni = 1'b1; pix_sync_ni = 1'b1; load_tick_i = 1'b0;
    repeat (2) @(negedge clk_i);
    if (n >= LOADS) m_cnt = (m_cnt + 1 >= per_of(cmd_i[5:4])) ? 0 : m_cnt + 1;
  endtask

  task automatic frames(int n);
    for (int i = 0; i < n; i++) blank_run(LOADS);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    check("R10", 32'(color_o), 32'h0);
    check("R10", 32'({blank_no, sync_no}), 32'b01);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    cmd_i = 8'h50;
    // directed selection corner cases
    pixel("R8", 8'hAB, 2'b11, 1'b0, 1'b0, 1'b0);
    cmd_i = 8'h10;
    pixel("R7", 8'h33, 2'b00, 1'b1, 1'b1, 1'b0);
    cmd_i = 8'h50;
    ovl_ctl_i = 4'b0001;
    pixel("R5", 8'h77, 2'b10, 1'b1, 1'b1, 1'b0);
    ovl_ctl_i = 4'b0011;
    pixel("R7", 8'h77, 2'b10, 1'b1, 1'b1, 1'b0);
    read_mask_i = 8'h3C; ovl_ctl_i = 4'h0;
    pixel("R1", 8'hE7, 2'b11, 1'b1, 1'b1, 1'b0);
    rand_pixels(120);

    // rate 01: 16 on / 16 off
    cmd_i = 8'h50;
    blank_run(LOADS - 1);
    probe("R4", 1'b0);
    blank_run(3 * LOADS);
    frames(14);
    probe("R3", 1'b0);
    frames(1);
    probe("R3", 1'b1);
    probe("R4", model_off() ? 1'b1 : 1'b0);
    rand_pixels(120);
    frames(15);
    probe("R3", 1'b1);
    frames(1);
    probe("R3", 1'b0);

    // rate 10: 32 on / 32 off
    cmd_i = 8'h60;
    frames(31);
    probe("R3", 1'b0);
    frames(1);
    probe("R3", 1'b1);
    rand_pixels(60);
    frames(31);
    probe("R3", 1'b1);
    frames(1);
    probe("R3", 1'b0);

    // rate 00: 16 on / 48 off
    cmd_i = 8'h40;
    frames(15);
    probe("R3", 1'b0);
    frames(1);
    probe("R2", 1'b1);
    frames(47);
    probe("R3", 1'b1);
    frames(1);
    probe("R3", 1'b0);

    // rate 11 behaves as 00
    cmd_i = 8'h70;
    frames(15);
    probe("R3", 1'b0);
    frames(1);
    probe("R3", 1'b1);
    rand_pixels(60);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule